// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sets the bit timing for an I2C master. It turns three register values into a train of SCL phases: a clock pre-divide value, a normal timing word, and a high-speed timing word. A bit-level engine uses the one-cycle strobes at the start of each low half, at the start of each high half, and at the sampling point in the middle of each high half. The bus period is the product of the pre-divide value, a sample count and a step count, each stored minus one. The engine holds `run` high for as long as the bus is busy. A master-code phase always runs with the normal timing. When the engine pulses `hs_go`, the generator moves to the high-speed sample and step values at the next low half, provided the high-speed word is enabled.

The controller is a three-state machine. `ST_IDLE` keeps SCL high and latches the divider and the normal half length when `run` rises. This is the transition IDLE→LOW. `ST_LOW` drives SCL low for one half period and then always moves on: LOW→HIGH. `ST_HIGH` drives SCL high for one half period. At its end it goes HIGH→LOW if `run` is still set, and it applies a pending high-speed switch on that same edge. Otherwise it goes HIGH→IDLE and drops back to the normal timing. Timing values are latched only when leaving idle, so a register write during a transfer cannot disturb it.

Top module: `scl_timing_gen`

## Requirements
- R1: With pre-divide field P (clk_div_cfg, meaning divide P+1), sample field S (norm_timing[10:8]) and step field T (norm_timing[5:0]), every SCL low half lasts (P+1)·(S+1)·(T+1) clock cycles. This is measured from the `tick_low` cycle to the next `tick_high` cycle.
- R2: Every SCL high half lasts the same number of cycles as the low half, so the SCL period is twice that length. It is measured from `tick_high` to the next `tick_low`.
- R3: `tick_sample` fires (P+1)·floor(H/2) cycles after `tick_high`, where H=(S+1)·(T+1). When H=1 it fires in the same cycle as `tick_high`.
- R4: `scl_o` is 0 throughout a low half and 1 otherwise, including idle. `tick_low` and `tick_high` are single-cycle strobes and are never both set.
- R5: While reset is asserted and just after it, `scl_o`=1, all three strobes are 0 and `hs_active`=0.
- R6: Changes to `clk_div_cfg` or `norm_timing` while `run` is held have no effect on the ongoing transfer. They take effect at the next start from idle.
- R7: When `run` falls during a low half, that low half and the following high half complete. SCL then stays high with no further `tick_low`.
- R8: A `hs_go` pulse during a transfer, with `hs_timing[1:0]`=3, switches the timing at the start of the next low half. The new timing uses sample field `hs_timing[14:12]` and step field `hs_timing[10:8]` with the same pre-divide. `hs_active` rises in that `tick_low` cycle.
- R9: When `hs_timing[1:0]`≠3, a `hs_go` pulse is ignored: the timing stays normal and `hs_active` stays 0.
- R10: A `hs_go` pulse while idle is ignored. Returning to idle clears `hs_active`, so the next transfer starts with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Bus busy request from the bit engine |
| hs_go | input | 1 | Pulse: switch to high-speed timing after the master code |
| clk_div_cfg | input | DIV_W | Pre-divide value minus one |
| norm_timing | input | 16 | Normal timing word (sample minus one, step minus one) |
| hs_timing | input | 16 | High-speed timing word (sample, step, enable) |
| scl_o | output | 1 | Generated SCL level |
| tick_low | output | 1 | Strobe on the first cycle of a low half |
| tick_high | output | 1 | Strobe on the first cycle of a high half |
| tick_sample | output | 1 | Strobe at the middle of a high half |
| hs_active | output | 1 | High-speed timing is in use |

## Verification
The bench targets the extremes of the divider product and the timing switches:
- Product extremes. A product of one (every strobe on adjacent cycles, sample and high coinciding) would expose an off-by-one in the half counter as a two-cycle half. The largest normal product (8·64) would expose a truncated half-length width as a short period.
- Mid-transfer register changes. Rewriting the timing during a transfer catches a design that reads the registers live: it would shorten the running bus period.
- High-speed switch. A switch requested mid-half catches a design that changes timing mid-half or never latches the pending request.
- Ignored requests. A disabled high-speed word, or a request made while idle, catches a design that enters high-speed timing without permission or stays in it after a transfer ends.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    // field widths of the timing words
    localparam int SAMP_W    = 3;
    localparam int N_STEP_W  = 6;
    localparam int H_STEP_W  = 3;
    localparam int TWORD_W   = 16;

    // field positions (decoded by software-visible layout)
    localparam int N_SAMP_LSB = 8;
    localparam int N_STEP_LSB = 0;
    localparam int H_SAMP_LSB = 12;
    localparam int H_STEP_LSB = 8;

    // half length in pre-divided ticks, up to 8*64
    localparam int HALF_W = SAMP_W + N_STEP_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_t;

endpackage

// File: rtl/scl_field_decode.sv
module scl_field_decode #(
    parameter int WORD_W   = 16,
    parameter int SAMP_LSB = 8,
    parameter int SAMP_W   = 3,
    parameter int STEP_LSB = 0,
    parameter int STEP_W   = 6,
    parameter int HALF_W   = 10,
    parameter bit HAS_EN   = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    output logic [HALF_W-1:0] half_len,
    output logic              enabled
);
    localparam int PROD_W = SAMP_W + STEP_W + 2;

    logic [SAMP_W:0]   samp_n;
    logic [STEP_W:0]   step_n;
    logic [PROD_W-1:0] prod;

    // stored values are count minus one
    assign samp_n   = {1'b0, word[SAMP_LSB +: SAMP_W]} + 1'b1;
    assign step_n   = {1'b0, word[STEP_LSB +: STEP_W]} + 1'b1;
    assign prod     = PROD_W'(samp_n) * PROD_W'(step_n);
    assign half_len = HALF_W'(prod);

    generate
        if (HAS_EN) begin : g_en
            assign enabled = (word[1:0] == 2'b11);
        end else begin : g_no_en
            assign enabled = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick,
    output logic             first
);
    logic [DIV_W-1:0] cnt;

    assign tick  = (cnt == div_m1);
    assign first = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               hs_go,
    input  logic [DIV_W-1:0]   clk_div_cfg,
    input  logic [TWORD_W-1:0] norm_timing,
    input  logic [TWORD_W-1:0] hs_timing,
    output logic               scl_o,
    output logic               tick_low,
    output logic               tick_high,
    output logic               tick_sample,
    output logic               hs_active
);
    scl_state_t        state, state_nx;
    logic [DIV_W-1:0]  act_div_m1;
    logic [HALF_W-1:0] act_half;
    logic [HALF_W-1:0] hcnt;
    logic [HALF_W-1:0] norm_half, hs_half;
    logic              hs_en, norm_en_unused;
    logic              hs_pend;
    logic              pre_tick, pre_first, pre_clr;
    logic              half_done, busy, first_cyc;
    logic              go_high_speed;

    scl_field_decode #(
        .WORD_W(TWORD_W), .SAMP_LSB(N_SAMP_LSB), .SAMP_W(SAMP_W),
        .STEP_LSB(N_STEP_LSB), .STEP_W(N_STEP_W), .HALF_W(HALF_W),
        .HAS_EN(1'b0)
    ) i_norm_dec (
        .word(norm_timing), .half_len(norm_half), .enabled(norm_en_unused)
    );

    scl_field_decode #(
        .WORD_W(TWORD_W), .SAMP_LSB(H_SAMP_LSB), .SAMP_W(SAMP_W),
        .STEP_LSB(H_STEP_LSB), .STEP_W(H_STEP_W), .HALF_W(HALF_W),
        .HAS_EN(1'b1)
    ) i_hs_dec (
        .word(hs_timing), .half_len(hs_half), .enabled(hs_en)
    );

    scl_prescale #(.DIV_W(DIV_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .div_m1(act_div_m1),
        .tick(pre_tick), .first(pre_first)
    );

    assign busy          = (state != ST_IDLE);
    assign half_done     = busy && pre_tick && (hcnt == act_half - 1'b1);
    assign pre_clr       = !busy || half_done;
    assign go_high_speed = (state == ST_HIGH) && half_done && run && hs_pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run)       state_nx = ST_LOW;
            ST_LOW:  if (half_done) state_nx = ST_HIGH;
            ST_HIGH: if (half_done) state_nx = run ? ST_LOW : ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // half counter in pre-divided ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hcnt <= '0;
        else if (!busy || half_done) hcnt <= '0;
        else if (pre_tick)           hcnt <= hcnt + 1'b1;
    end

    // active timing, latched only at idle exit or at the speed switch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div_m1 <= '0;
            act_half   <= HALF_W'(1);
            hs_active  <= 1'b0;
            hs_pend    <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                hs_active <= 1'b0;
                hs_pend   <= 1'b0;
                if (run) begin
                    act_div_m1 <= clk_div_cfg;
                    act_half   <= norm_half;
                end
            end else if (go_high_speed) begin
                act_half  <= hs_half;
                hs_active <= 1'b1;
                hs_pend   <= 1'b0;
            end else if (hs_go && hs_en && !hs_active) begin
                hs_pend <= 1'b1;
            end
            if ((state == ST_HIGH) && half_done && !run) begin
                hs_active <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        first_cyc   = pre_first && (hcnt == '0);
        scl_o       = (state != ST_LOW);
        tick_low    = (state == ST_LOW) && first_cyc;
        tick_high   = (state == ST_HIGH) && first_cyc;
        tick_sample = (state == ST_HIGH) && pre_first && (hcnt == (act_half >> 1));
    end

endmodule

// File: rtl/scl_timing_checker.sv
module scl_timing_checker #(
    parameter int DIV_W  = 4,
    parameter int HALF_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_o,
    input logic              tick_low,
    input logic              tick_high,
    input logic              tick_sample,
    input logic              hs_active,
    input logic              busy,
    input logic [DIV_W-1:0]  act_div_m1,
    input logic [HALF_W-1:0] act_half
);
    a_r4_one_phase_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_low, tick_high}));

    a_r4_low_strobe_level: assert property (@(posedge clk) disable iff (!rst_n)
        tick_low |-> !scl_o);

    a_r3_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |-> scl_o);

    a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(act_div_m1));

    a_r6_half_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$rose(hs_active)) |-> $stable(act_half));

    a_r8_switch_at_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active) |-> tick_low);

    a_r10_idle_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !hs_active);

    a_r7_idle_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && !tick_low));

endmodule

bind scl_timing_gen scl_timing_checker #(
    .DIV_W(DIV_W), .HALF_W(scl_timing_pkg::HALF_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .tick_low(tick_low),
    .tick_high(tick_high), .tick_sample(tick_sample), .hs_active(hs_active),
    .busy(busy), .act_div_m1(act_div_m1), .act_half(act_half)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    localparam int CLK_NS = 20;
    localparam int NV = 6;
    // {div_m1, samp_m1, step_m1, expected half cycles, expected sample offset}
    localparam int VEC [NV][5] = '{
        '{3, 1, 4,  40,  20},
        '{0, 0, 0,   1,   0},
        '{1, 2, 2,  18,   8},
        '{0, 7, 63, 512, 256},
        '{2, 0, 1,   6,   3},
        '{15, 0, 0, 16,   0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        hs_go = 1'b0;
    logic [3:0]  clk_div_cfg = '0;
    logic [15:0] norm_timing = '0;
    logic [15:0] hs_timing = '0;
    logic        scl_o, tick_low, tick_high, tick_sample, hs_active;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    scl_timing_gen #(.DIV_W(4)) i_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .hs_go(hs_go),
        .clk_div_cfg(clk_div_cfg), .norm_timing(norm_timing),
        .hs_timing(hs_timing), .scl_o(scl_o), .tick_low(tick_low),
        .tick_high(tick_high), .tick_sample(tick_sample), .hs_active(hs_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // waits for the next tick_low, returns low, sample and high lengths
    task automatic measure(output int lo, output int mid, output int hi);
        int n;
        n = 0;
        while (!tick_low && n < 20000) begin @(negedge clk); n++; end
        chk("R4 scl low at tick_low", int'(scl_o), 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_high && n < 20000);
        lo = n;
        chk("R4 scl high at tick_high", int'(scl_o), 1);
        n = 0;
        while (!tick_sample && n < 20000) begin @(negedge clk); n++; end
        mid = n;
        do begin @(negedge clk); n++; end while (!tick_low && n < 20000);
        hi = n;
    endtask

    task automatic set_norm(input int d, input int s, input int t);
        clk_div_cfg = 4'(d);
        norm_timing = 16'((s << 8) | t);
    endtask

    initial begin
        #(CLK_NS * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lo, mid, hi;
        // R5: reset state
        cycles(3);
        chk("R5 scl_o", int'(scl_o), 1);
        chk("R5 strobes", int'({tick_low, tick_high, tick_sample}), 0);
        chk("R5 hs_active", int'(hs_active), 0);
        rst_n = 1'b1;
        cycles(3);
        chk("R5 idle after reset", int'({scl_o, tick_low, tick_high, hs_active}), 8);

        // R1 R2 R3: vector table
        for (int v = 0; v < NV; v++) begin
            run = 1'b0;
            set_norm(VEC[v][0], VEC[v][1], VEC[v][2]);
            cycles(4);
            run = 1'b1;
            measure(lo, mid, hi);
            chk("R1 low half", lo, VEC[v][3]);
            chk("R3 sample offset", mid, VEC[v][4]);
            chk("R2 high half", hi, VEC[v][3]);
            run = 1'b0;
            cycles(2 * VEC[v][3] + 8);
        end

        // R6: mid-transfer change has no effect until idle restart
        set_norm(1, 0, 3);
        cycles(2);
        run = 1'b1;
        measure(lo, mid, hi);
        chk("R6 first period", lo, 8);
        set_norm(0, 1, 1);
        measure(lo, mid, hi);
        chk("R6 low held", lo, 8);
        chk("R6 high held", hi, 8);
        run = 1'b0;
        cycles(24);
        run = 1'b1;
        measure(lo, mid, hi);
        chk("R6 new low after idle", lo, 4);
        chk("R6 new sample after idle", mid, 2);

        // R7: run drop during low half
        run = 1'b0;
        cycles(16);
        set_norm(1, 1, 4);   // half 20
        run = 1'b1;
        while (!tick_low) @(negedge clk);
        @(negedge clk);
        run = 1'b0;
        begin
            int n, seen_low, scl_bad;
            n = 1; seen_low = 0; scl_bad = 0;
            while (!tick_high && n < 1000) begin @(negedge clk); n++; end
            chk("R7 low half completes", n, 20);
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (tick_low) seen_low++;
                if (i >= 20 && !scl_o) scl_bad++;
            end
            chk("R7 no further tick_low", seen_low, 0);
            chk("R7 scl stays high", scl_bad, 0);
        end

        // R8: switch to high-speed timing
        hs_timing = 16'h1203;   // samp_m1=1, step_m1=2, enabled
        run = 1'b1;
        while (!tick_low) @(negedge clk);
        chk("R8 normal before switch", int'(hs_active), 0);
        @(negedge clk);
        hs_go = 1'b1;
        @(negedge clk);
        hs_go = 1'b0;
        measure(lo, mid, hi);
        chk("R8 hs low half", lo, 12);
        chk("R8 hs sample", mid, 6);
        chk("R8 hs high half", hi, 12);
        chk("R8 hs_active", int'(hs_active), 1);

        // R10: back to normal after idle
        run = 1'b0;
        cycles(40);
        chk("R10 hs_active cleared", int'(hs_active), 0);
        run = 1'b1;
        measure(lo, mid, hi);
        chk("R10 normal after idle", lo, 20);

        // R9: disabled high-speed word
        run = 1'b0;
        cycles(48);
        hs_timing = 16'h1200;
        run = 1'b1;
        while (!tick_low) @(negedge clk);
        @(negedge clk);
        hs_go = 1'b1;
        @(negedge clk);
        hs_go = 1'b0;
        measure(lo, mid, hi);
        chk("R9 timing unchanged", lo, 20);
        chk("R9 hs_active low", int'(hs_active), 0);

        // R10: hs_go while idle ignored
        run = 1'b0;
        cycles(48);
        hs_timing = 16'h1203;
        hs_go = 1'b1;
        @(negedge clk);
        hs_go = 1'b0;
        cycles(2);
        run = 1'b1;
        measure(lo, mid, hi);
        chk("R10 idle hs_go first", lo, 20);
        measure(lo, mid, hi);
        chk("R10 idle hs_go second", lo, 20);
        chk("R10 idle hs_go flag", int'(hs_active), 0);
        run = 1'b0;
        cycles(50);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule